// File: doc/BRIEF.md
# Direct-Mapped Translation Buffer with Access Permission Check

This block caches translations from linear 4 KiB page frames to physical page frames. Each entry records the physical frame, a six-bit permission mask, a protection key and a memory type. The slots are direct-mapped. A fill loads one slot on a clock edge and replaces whatever that slot held before. The block also offers two ways to remove translations: one flushes every slot, and the other removes a single frame.

A lookup is combinational. It takes a linear address, an access length (bytes minus one), an alignment mask, a user/supervisor flag and an access kind. In the same cycle it returns the following:
- a hit flag;
- the physical address, formed from the cached frame and the untouched page offset;
- a permission verdict;
- the memory type.

The slot is chosen from the sum of the address and the access length. An access that runs past the end of its page therefore lands on a neighbouring slot and misses. The caller must then split the access.

The block holds two per-key enable masks, one for reads and one for writes, loaded through a small write port. These masks further restrict read and write permission.

Top module: `dm_tlb`

## Requirements
- R1: After reset every slot is empty, so every lookup misses, and both per-key enable masks are all ones.
- R2: From the cycle after a fill of linear frame F, a lookup in frame F hits. It returns the filled physical frame in address bits [31:12] and the lookup address bits [11:0] unchanged. The fill is not visible to a lookup in the same cycle as the fill.
- R3: The slot of a fill is bits [9:0] of the linear frame. A later fill of a different frame with the same slot replaces the earlier entry, so the earlier frame then misses.
- R4: The lookup slot is bits [21:12] of (address + length). An access whose last byte crosses into the next page always misses. An access that ends on the last byte of a cached page hits.
- R5: A lookup whose address bits [11:0] ANDed with the alignment mask are nonzero misses. With those bits zero, a cached frame hits.
- R6: Permission mask bits are as follows: bit0 supervisor read, bit1 user read, bit2 supervisor write, bit3 user write, bit4 supervisor execute, bit5 user execute. The kind code is 0 read, 1 write, 2 execute, 3 none. A hit is permitted when the mask bit for the requested kind and privilege is set. Kind 3 is never permitted.
- R7: A read also needs the read-enable mask bit selected by the entry's 4-bit key. A write also needs the matching write-enable bit. Execute ignores both masks. A key-mask write loads both 16-bit masks at the next edge.
- R8: On a hit the memory type output is the value stored with the entry. On a miss it is 8 (invalid).
- R9: A single-frame invalidate empties the slot of the given frame only when that slot holds that frame. Other frames, including one sharing the slot, are unaffected.
- R10: A flush empties every slot at the next edge. It takes precedence over a fill in the same cycle. A fill in turn takes precedence over a single-frame invalidate.
- R11: On a miss the physical address output is zero and the permission verdict is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_addr | input | 32 | Lookup linear address |
| lk_len | input | 4 | Access length in bytes minus one |
| lk_align | input | 12 | Alignment mask on the page offset |
| lk_user | input | 1 | 1 for user privilege, 0 for supervisor |
| lk_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 none |
| lk_hit | output | 1 | Lookup hit |
| lk_paddr | output | 32 | Translated physical address, zero on miss |
| lk_perm_ok | output | 1 | Access permitted |
| lk_memtype | output | 4 | Memory type of the entry, 8 on miss |
| fl_en | input | 1 | Fill strobe |
| fl_lframe | input | 20 | Linear frame to load |
| fl_pframe | input | 20 | Physical frame to load |
| fl_perm | input | 6 | Permission mask to load |
| fl_key | input | 4 | Protection key to load |
| fl_memtype | input | 4 | Memory type to load |
| inv_en | input | 1 | Single-frame invalidate strobe |
| inv_frame | input | 20 | Linear frame to invalidate |
| inv_all | input | 1 | Flush every slot |
| key_we | input | 1 | Key-mask write strobe |
| key_rd_mask | input | 16 | New read-enable mask, bit k for key k |
| key_wr_mask | input | 16 | New write-enable mask, bit k for key k |

## Verification
The bench looks up frames in several situations:
- Frames it has just filled, at different offsets and privilege levels.
- Frames that collide on one slot, to show that the direct mapping replaces entries.
- Accesses that end exactly on the page boundary and one byte past it. These separate the length-shifted slot choice from a plain frame index.
- Offsets with and without bits under the alignment mask.
- Every kind against sparse permission masks, and keyed entries with one mask bit cleared. These show which checks consult the key masks and which ignore them.
- A flush issued together with a fill, and an invalidate aimed at a slot-sharing stranger frame. These show the order of precedence and the exact tag match.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_NONE  = 2'd3
    } acc_kind_e;

    localparam int          PERM_W     = 6;
    localparam logic [3:0]  MT_UNCACHE = 4'd0;
    localparam logic [3:0]  MT_NONE    = 4'd8;
endpackage

// File: rtl/tlb_slot_index.sv
module tlb_slot_index #(
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 12,
    parameter int IDX_W     = 10,
    parameter int LEN_W     = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  len,
    output logic [IDX_W-1:0]  idx
);
    // slot of the last byte touched by the access
    always_comb idx = IDX_W'((addr + ADDR_W'(len)) >> PAGE_BITS);
endmodule

// File: rtl/tlb_perm_check.sv
module tlb_perm_check
    import tlb_pkg::*;
#(
    parameter int KEY_W     = 4,
    parameter bit USE_PKEYS = 1'b1
) (
    input  logic [PERM_W-1:0]      perm,
    input  logic [KEY_W-1:0]       key,
    input  logic                   user,
    input  logic [1:0]             kind,
    input  logic [(1<<KEY_W)-1:0]  rd_en,
    input  logic [(1<<KEY_W)-1:0]  wr_en,
    output logic                   ok
);
    logic       rd_key, wr_key;
    logic [1:0] rd_pair, wr_pair, ex_pair;

    generate
        if (USE_PKEYS) begin : g_keys
            assign rd_key = rd_en[key];
            assign wr_key = wr_en[key];
        end else begin : g_nokeys
            assign rd_key = 1'b1;
            assign wr_key = 1'b1;
        end
    endgenerate

    assign rd_pair = perm[1:0];
    assign wr_pair = perm[3:2];
    assign ex_pair = perm[5:4];

    always_comb begin
        unique case (acc_kind_e'(kind))
            ACC_READ:  ok = rd_pair[user] & rd_key;
            ACC_WRITE: ok = wr_pair[user] & wr_key;
            ACC_EXEC:  ok = ex_pair[user];
            default:   ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/dm_tlb.sv
module dm_tlb
    import tlb_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int PAGE_BITS   = 12,
    parameter int ENTRIES     = 1024,
    parameter int LEN_W       = 4,
    parameter int KEY_W       = 4,
    parameter int MT_W        = 4,
    parameter bit USE_PKEYS   = 1'b1,
    parameter bit USE_MEMTYPE = 1'b1,
    localparam int FRAME_W    = ADDR_W - PAGE_BITS,
    localparam int NKEYS      = 1 << KEY_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    lk_addr,
    input  logic [LEN_W-1:0]     lk_len,
    input  logic [PAGE_BITS-1:0] lk_align,
    input  logic                 lk_user,
    input  logic [1:0]           lk_kind,
    output logic                 lk_hit,
    output logic [ADDR_W-1:0]    lk_paddr,
    output logic                 lk_perm_ok,
    output logic [MT_W-1:0]      lk_memtype,
    input  logic                 fl_en,
    input  logic [FRAME_W-1:0]   fl_lframe,
    input  logic [FRAME_W-1:0]   fl_pframe,
    input  logic [PERM_W-1:0]    fl_perm,
    input  logic [KEY_W-1:0]     fl_key,
    input  logic [MT_W-1:0]      fl_memtype,
    input  logic                 inv_en,
    input  logic [FRAME_W-1:0]   inv_frame,
    input  logic                 inv_all,
    input  logic                 key_we,
    input  logic [NKEYS-1:0]     key_rd_mask,
    input  logic [NKEYS-1:0]     key_wr_mask
);
    localparam int IDX_W = $clog2(ENTRIES);
    // tag carries one extra top bit so that all ones never equals a real frame
    localparam int TAG_W = FRAME_W + 1;

    typedef struct packed {
        logic [TAG_W-1:0]   tag;
        logic [FRAME_W-1:0] ppf;
        logic [PERM_W-1:0]  perm;
        logic [KEY_W-1:0]   key;
        logic [MT_W-1:0]    mt;
    } entry_t;

    typedef struct packed {
        entry_t [ENTRIES-1:0] ent;
        logic [NKEYS-1:0]     rd_en;
        logic [NKEYS-1:0]     wr_en;
    } state_t;

    state_t st_d, st_q, st_rst;

    // ---------------- lookup path ----------------
    logic [IDX_W-1:0]  lk_idx;
    entry_t            sel;
    logic [ADDR_W-1:0] masked;
    logic              perm_raw;

    tlb_slot_index #(
        .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .IDX_W(IDX_W), .LEN_W(LEN_W)
    ) i_lk_index (
        .addr(lk_addr), .len(lk_len), .idx(lk_idx)
    );

    always_comb begin
        sel    = st_q.ent[lk_idx];
        masked = lk_addr & {{FRAME_W{1'b1}}, lk_align};
        lk_hit = (sel.tag == {1'b0, masked[ADDR_W-1:PAGE_BITS]})
                 && (masked[PAGE_BITS-1:0] == '0);
        lk_paddr = lk_hit ? {sel.ppf, lk_addr[PAGE_BITS-1:0]} : '0;
    end

    tlb_perm_check #(
        .KEY_W(KEY_W), .USE_PKEYS(USE_PKEYS)
    ) i_perm (
        .perm(sel.perm), .key(sel.key), .user(lk_user), .kind(lk_kind),
        .rd_en(st_q.rd_en), .wr_en(st_q.wr_en), .ok(perm_raw)
    );

    assign lk_perm_ok = lk_hit & perm_raw;

    generate
        if (USE_MEMTYPE) begin : g_mt
            assign lk_memtype = lk_hit ? sel.mt : MT_W'(MT_NONE);
        end else begin : g_nomt
            assign lk_memtype = lk_hit ? MT_W'(MT_UNCACHE) : MT_W'(MT_NONE);
        end
    endgenerate

    // ---------------- update path ----------------
    logic [IDX_W-1:0] fl_idx, inv_idx;
    assign fl_idx  = fl_lframe[IDX_W-1:0];
    assign inv_idx = inv_frame[IDX_W-1:0];

    always_comb begin
        st_rst = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            st_rst.ent[i].tag = '1;
        end
        st_rst.rd_en = '1;
        st_rst.wr_en = '1;
    end

    always_comb begin
        st_d = st_q;
        // lowest precedence: single-frame invalidate on exact tag match
        if (inv_en && (st_q.ent[inv_idx].tag == {1'b0, inv_frame})) begin
            st_d.ent[inv_idx].tag  = '1;
            st_d.ent[inv_idx].perm = '0;
        end
        if (fl_en) begin
            st_d.ent[fl_idx].tag  = {1'b0, fl_lframe};
            st_d.ent[fl_idx].ppf  = fl_pframe;
            st_d.ent[fl_idx].perm = fl_perm;
            st_d.ent[fl_idx].key  = fl_key;
            st_d.ent[fl_idx].mt   = fl_memtype;
        end
        if (key_we) begin
            st_d.rd_en = key_rd_mask;
            st_d.wr_en = key_wr_mask;
        end
        // highest precedence: flush
        if (inv_all) begin
            for (int i = 0; i < ENTRIES; i++) begin
                st_d.ent[i].tag  = '1;
                st_d.ent[i].perm = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= st_rst;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/dm_tlb_chk.sv
module dm_tlb_chk #(
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 12,
    parameter int LEN_W     = 4,
    parameter int MT_W      = 4,
    localparam int FRAME_W  = ADDR_W - PAGE_BITS
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_W-1:0]    lk_addr,
    input logic [LEN_W-1:0]     lk_len,
    input logic [PAGE_BITS-1:0] lk_align,
    input logic [1:0]           lk_kind,
    input logic                 lk_hit,
    input logic [ADDR_W-1:0]    lk_paddr,
    input logic                 lk_perm_ok,
    input logic [MT_W-1:0]      lk_memtype,
    input logic                 fl_en,
    input logic [FRAME_W-1:0]   fl_lframe,
    input logic [FRAME_W-1:0]   fl_pframe,
    input logic                 inv_all
);
    logic [PAGE_BITS:0] off_end;
    assign off_end = {1'b0, lk_addr[PAGE_BITS-1:0]} + (PAGE_BITS+1)'(lk_len);

    // R1
    reset_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !lk_hit);

    // R2
    fill_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(fl_en) && !$past(inv_all) && lk_len == '0 && lk_align == '0
         && lk_addr[ADDR_W-1:PAGE_BITS] == $past(fl_lframe))
        |-> (lk_hit && lk_paddr == {$past(fl_pframe), lk_addr[PAGE_BITS-1:0]}));

    // R4
    cross_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        off_end[PAGE_BITS] |-> !lk_hit);

    // R5
    misalign_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((lk_addr[PAGE_BITS-1:0] & lk_align) != '0) |-> !lk_hit);

    // R6
    no_kind_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_kind == 2'd3) |-> !lk_perm_ok);

    // R8
    miss_memtype_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_memtype == MT_W'(8)));

    // R10
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(inv_all)) |-> !lk_hit);

    // R11
    miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (!lk_perm_ok && lk_paddr == '0));
endmodule

bind dm_tlb dm_tlb_chk #(
    .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .LEN_W(LEN_W), .MT_W(MT_W)
) i_dm_tlb_chk (
    .clk(clk), .rst_n(rst_n), .lk_addr(lk_addr), .lk_len(lk_len),
    .lk_align(lk_align), .lk_kind(lk_kind), .lk_hit(lk_hit),
    .lk_paddr(lk_paddr), .lk_perm_ok(lk_perm_ok), .lk_memtype(lk_memtype),
    .fl_en(fl_en), .fl_lframe(fl_lframe), .fl_pframe(fl_pframe),
    .inv_all(inv_all)
);

// File: tb/test_dm_tlb.sv
`timescale 1ns/1ps
module test_dm_tlb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] lk_addr;
    logic [3:0]  lk_len;
    logic [11:0] lk_align;
    logic        lk_user;
    logic [1:0]  lk_kind;
    logic        lk_hit;
    logic [31:0] lk_paddr;
    logic        lk_perm_ok;
    logic [3:0]  lk_memtype;
    logic        fl_en;
    logic [19:0] fl_lframe, fl_pframe;
    logic [5:0]  fl_perm;
    logic [3:0]  fl_key, fl_memtype;
    logic        inv_en;
    logic [19:0] inv_frame;
    logic        inv_all;
    logic        key_we;
    logic [15:0] key_rd_mask, key_wr_mask;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    dm_tlb i_dm_tlb (
        .clk(clk), .rst_n(rst_n), .lk_addr(lk_addr), .lk_len(lk_len),
        .lk_align(lk_align), .lk_user(lk_user), .lk_kind(lk_kind),
        .lk_hit(lk_hit), .lk_paddr(lk_paddr), .lk_perm_ok(lk_perm_ok),
        .lk_memtype(lk_memtype), .fl_en(fl_en), .fl_lframe(fl_lframe),
        .fl_pframe(fl_pframe), .fl_perm(fl_perm), .fl_key(fl_key),
        .fl_memtype(fl_memtype), .inv_en(inv_en), .inv_frame(inv_frame),
        .inv_all(inv_all), .key_we(key_we), .key_rd_mask(key_rd_mask),
        .key_wr_mask(key_wr_mask)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // drive a lookup just after a falling edge and sample 1 ns later
    task automatic look(input logic [31:0] a, input logic [3:0] len,
                        input logic [11:0] al, input logic u, input logic [1:0] k);
        @(negedge clk);
        lk_addr = a; lk_len = len; lk_align = al; lk_user = u; lk_kind = k;
        #1;
    endtask

    task automatic expect_lk(input string req, input logic [31:0] a, input logic [3:0] len,
                             input logic [11:0] al, input logic u, input logic [1:0] k,
                             input logic eh, input logic [31:0] ep, input logic eok);
        look(a, len, al, u, k);
        chk(lk_hit == eh, req, "hit", 32'(lk_hit), 32'(eh));
        chk(lk_paddr == ep, req, "paddr", lk_paddr, ep);
        chk(lk_perm_ok == eok, req, "perm_ok", 32'(lk_perm_ok), 32'(eok));
    endtask

    task automatic fill(input logic [19:0] lf, input logic [19:0] pf,
                        input logic [5:0] p, input logic [3:0] key, input logic [3:0] mt);
        @(negedge clk);
        fl_en = 1'b1; fl_lframe = lf; fl_pframe = pf; fl_perm = p; fl_key = key; fl_memtype = mt;
        @(negedge clk);
        fl_en = 1'b0;
    endtask

    task automatic set_keys(input logic [15:0] rd, input logic [15:0] wr);
        @(negedge clk);
        key_we = 1'b1; key_rd_mask = rd; key_wr_mask = wr;
        @(negedge clk);
        key_we = 1'b0;
    endtask

    task automatic t_reset;
        // R1: empty after reset, masks all enabled (checked later via keyed reads)
        expect_lk("R1", 32'h0000_0000, 4'd0, 12'h000, 1'b0, 2'd0, 1'b0, 32'h0, 1'b0);
        expect_lk("R1", 32'hFFFF_F000, 4'd0, 12'h000, 1'b0, 2'd0, 1'b0, 32'h0, 1'b0);
        look(32'h1234_5678, 4'd0, 12'h000, 1'b0, 2'd0);
        chk(lk_memtype == 4'd8, "R8", "miss memtype", 32'(lk_memtype), 32'd8);
    endtask

    task automatic t_fill_hit;
        // R2: same-cycle invisibility, then hit with offset passthrough
        @(negedge clk);
        fl_en = 1'b1; fl_lframe = 20'h12345; fl_pframe = 20'hABCDE; fl_perm = 6'h3F;
        fl_key = 4'd0; fl_memtype = 4'd6;
        lk_addr = 32'h1234_5678; lk_len = 4'd0; lk_align = 12'h0; lk_user = 1'b0; lk_kind = 2'd0;
        #1;
        chk(lk_hit == 1'b0, "R2", "same-cycle hit", 32'(lk_hit), 32'h0);
        @(negedge clk);
        fl_en = 1'b0;
        expect_lk("R2", 32'h1234_5678, 4'd0, 12'h000, 1'b0, 2'd0, 1'b1, 32'hABCD_E678, 1'b1);
        expect_lk("R2", 32'h1234_5000, 4'd0, 12'h000, 1'b1, 2'd1, 1'b1, 32'hABCD_E000, 1'b1);
        // R1: all-ones key masks leave keyed reads allowed
        fill(20'h00777, 20'h00888, 6'h01, 4'd9, 4'd0);
        expect_lk("R1", 32'h0077_7010, 4'd0, 12'h000, 1'b0, 2'd0, 1'b1, 32'h0088_8010, 1'b1);
        // R8
        look(32'h1234_5678, 4'd0, 12'h000, 1'b0, 2'd0);
        chk(lk_memtype == 4'd6, "R8", "hit memtype", 32'(lk_memtype), 32'd6);
        // R11: miss output quiet
        expect_lk("R11", 32'h0999_9000, 4'd0, 12'h000, 1'b0, 2'd0, 1'b0, 32'h0, 1'b0);
    endtask

    task automatic t_conflict;
        // R3: same slot 0x345, different frame
        fill(20'h55345, 20'h11111, 6'h3F, 4'd0, 4'd4);
        expect_lk("R3", 32'h1234_5000, 4'd0, 12'h000, 1'b0, 2'd0, 1'b0, 32'h0, 1'b0);
        expect_lk("R3", 32'h5534_5ABC, 4'd0, 12'h000, 1'b0, 2'd0, 1'b1, 32'h1111_1ABC, 1'b1);
    endtask

    task automatic t_cross;
        fill(20'h12345, 20'hABCDE, 6'h3F, 4'd0, 4'd6);
        fill(20'h12346, 20'hABCDF, 6'h3F, 4'd0, 4'd6);
        // R4: ends on last byte of page -> hit
        expect_lk("R4", 32'h1234_5FFC, 4'd3, 12'h000, 1'b0, 2'd0, 1'b1, 32'hABCD_EFFC, 1'b1);
        // R4: one byte past the page -> next slot, miss
        expect_lk("R4", 32'h1234_5FFC, 4'd4, 12'h000, 1'b0, 2'd0, 1'b0, 32'h0, 1'b0);
        expect_lk("R4", 32'h1234_5FF1, 4'd15, 12'h000, 1'b0, 2'd0, 1'b0, 32'h0, 1'b0);
    endtask

    task automatic t_align;
        // R5
        expect_lk("R5", 32'h1234_5004, 4'd3, 12'h003, 1'b0, 2'd0, 1'b1, 32'hABCD_E004, 1'b1);
        expect_lk("R5", 32'h1234_5006, 4'd1, 12'h003, 1'b0, 2'd0, 1'b0, 32'h0, 1'b0);
        expect_lk("R5", 32'h1234_5008, 4'd7, 12'h007, 1'b0, 2'd0, 1'b1, 32'hABCD_E008, 1'b1);
    endtask

    task automatic t_perm;
        // R6: supervisor read only
        fill(20'h00100, 20'h00200, 6'h01, 4'd0, 4'd0);
        expect_lk("R6", 32'h0010_0000, 4'd0, 12'h0, 1'b0, 2'd0, 1'b1, 32'h0020_0000, 1'b1);
        expect_lk("R6", 32'h0010_0000, 4'd0, 12'h0, 1'b1, 2'd0, 1'b1, 32'h0020_0000, 1'b0);
        expect_lk("R6", 32'h0010_0000, 4'd0, 12'h0, 1'b0, 2'd1, 1'b1, 32'h0020_0000, 1'b0);
        // R6: user write + user execute
        fill(20'h00101, 20'h00201, 6'h28, 4'd0, 4'd0);
        expect_lk("R6", 32'h0010_1000, 4'd0, 12'h0, 1'b1, 2'd1, 1'b1, 32'h0020_1000, 1'b1);
        expect_lk("R6", 32'h0010_1000, 4'd0, 12'h0, 1'b0, 2'd1, 1'b1, 32'h0020_1000, 1'b0);
        expect_lk("R6", 32'h0010_1000, 4'd0, 12'h0, 1'b1, 2'd2, 1'b1, 32'h0020_1000, 1'b1);
        expect_lk("R6", 32'h0010_1000, 4'd0, 12'h0, 1'b0, 2'd2, 1'b1, 32'h0020_1000, 1'b0);
        expect_lk("R6", 32'h0010_1000, 4'd0, 12'h0, 1'b1, 2'd0, 1'b1, 32'h0020_1000, 1'b0);
        // R6: supervisor execute only, and kind 3 never allowed
        fill(20'h00102, 20'h00202, 6'h10, 4'd0, 4'd0);
        expect_lk("R6", 32'h0010_2000, 4'd0, 12'h0, 1'b0, 2'd2, 1'b1, 32'h0020_2000, 1'b1);
        fill(20'h00103, 20'h00203, 6'h3F, 4'd0, 4'd0);
        expect_lk("R6", 32'h0010_3000, 4'd0, 12'h0, 1'b0, 2'd3, 1'b1, 32'h0020_3000, 1'b0);
    endtask

    task automatic t_keys;
        // R7: key 5, full permission
        fill(20'h00300, 20'h00400, 6'h3F, 4'd5, 4'd0);
        set_keys(16'hFFDF, 16'hFFFF);
        expect_lk("R7", 32'h0030_0000, 4'd0, 12'h0, 1'b0, 2'd0, 1'b1, 32'h0040_0000, 1'b0);
        expect_lk("R7", 32'h0030_0000, 4'd0, 12'h0, 1'b0, 2'd1, 1'b1, 32'h0040_0000, 1'b1);
        expect_lk("R7", 32'h0030_0000, 4'd0, 12'h0, 1'b1, 2'd2, 1'b1, 32'h0040_0000, 1'b1);
        set_keys(16'hFFFF, 16'hFFDF);
        expect_lk("R7", 32'h0030_0000, 4'd1, 12'h0, 1'b1, 2'd0, 1'b1, 32'h0040_0000, 1'b1);
        expect_lk("R7", 32'h0030_0000, 4'd0, 12'h0, 1'b1, 2'd1, 1'b1, 32'h0040_0000, 1'b0);
        // R7: a different key is unaffected by key 5 being disabled
        fill(20'h00301, 20'h00401, 6'h3F, 4'd6, 4'd0);
        expect_lk("R7", 32'h0030_1000, 4'd0, 12'h0, 1'b1, 2'd1, 1'b1, 32'h0040_1000, 1'b1);
        set_keys(16'hFFFF, 16'hFFFF);
    endtask

    task automatic t_single_inv;
        fill(20'h00111, 20'h00AAA, 6'h3F, 4'd0, 4'd0);
        fill(20'h00222, 20'h00BBB, 6'h3F, 4'd0, 4'd0);
        // R9: stranger frame on same slot leaves entry alone
        @(negedge clk); inv_en = 1'b1; inv_frame = 20'h77111;
        @(negedge clk); inv_en = 1'b0;
        expect_lk("R9", 32'h0011_1ABC, 4'd0, 12'h0, 1'b0, 2'd0, 1'b1, 32'h00AA_AABC, 1'b1);
        @(negedge clk); inv_en = 1'b1; inv_frame = 20'h00111;
        @(negedge clk); inv_en = 1'b0;
        expect_lk("R9", 32'h0011_1ABC, 4'd0, 12'h0, 1'b0, 2'd0, 1'b0, 32'h0, 1'b0);
        expect_lk("R9", 32'h0022_2000, 4'd0, 12'h0, 1'b0, 2'd0, 1'b1, 32'h00BB_B000, 1'b1);
        // R10: fill beats single invalidate on the same slot
        @(negedge clk);
        inv_en = 1'b1; inv_frame = 20'h00222;
        fl_en = 1'b1; fl_lframe = 20'h00222; fl_pframe = 20'h00CCC; fl_perm = 6'h3F;
        fl_key = 4'd0; fl_memtype = 4'd1;
        @(negedge clk); inv_en = 1'b0; fl_en = 1'b0;
        expect_lk("R10", 32'h0022_2000, 4'd0, 12'h0, 1'b0, 2'd0, 1'b1, 32'h00CC_C000, 1'b1);
    endtask

    task automatic t_flush;
        // R10: flush together with a fill: nothing survives
        @(negedge clk);
        inv_all = 1'b1;
        fl_en = 1'b1; fl_lframe = 20'h00500; fl_pframe = 20'h00600; fl_perm = 6'h3F;
        fl_key = 4'd0; fl_memtype = 4'd0;
        @(negedge clk); inv_all = 1'b0; fl_en = 1'b0;
        expect_lk("R10", 32'h0050_0000, 4'd0, 12'h0, 1'b0, 2'd0, 1'b0, 32'h0, 1'b0);
        expect_lk("R10", 32'h0022_2000, 4'd0, 12'h0, 1'b0, 2'd0, 1'b0, 32'h0, 1'b0);
        expect_lk("R10", 32'h5534_5000, 4'd0, 12'h0, 1'b0, 2'd0, 1'b0, 32'h0, 1'b0);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog: actual running expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        lk_addr = '0; lk_len = '0; lk_align = '0; lk_user = 1'b0; lk_kind = 2'd0;
        fl_en = 1'b0; fl_lframe = '0; fl_pframe = '0; fl_perm = '0; fl_key = '0; fl_memtype = '0;
        inv_en = 1'b0; inv_frame = '0; inv_all = 1'b0;
        key_we = 1'b0; key_rd_mask = '0; key_wr_mask = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fill_hit();
        t_conflict();
        t_cross();
        t_align();
        t_perm();
        t_keys();
        t_single_inv();
        t_flush();
        repeat (2) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule